// File: doc/BRIEF.md
# DMA Channel Status and Condition Register Front End

This block holds the registers of one descriptor-driven DMA channel and sits on a simple 32-bit register bus. Software never writes the status word directly. It writes a control word instead. The top half of that word chooses which status bits change, and the bottom half supplies their new values. A device can also raise any of the eight low status bits through a strobed input port.

Three select registers each hold an 8-bit mask and an 8-bit value. Each select drives one condition output: interrupt, branch or wait. A condition is raised while the masked device bits of status equal the programmed value. The block also holds a 64-bit command pointer for the descriptor engine. When the engine signals that a descriptor is complete, the block latches a completion record for the engine to store. That record is the low half of status together with a residual byte count.

Top module: `dma_chan_regs`

## Requirements
- R1: Synchronous active-high reset clears status, the command pointer and all three selects. After reset no condition output is asserted and status reads zero.
- R2: A write to offset 0x00 changes status bit i (0..15) to written bit i only where written bit 16+i is 1. All other status bits hold.
- R3: Reads of offset 0x00 return zero. Writes to offset 0x04 have no effect on status. Reads of unmapped offsets return zero, and writes to them change no register.
- R4: Offset 0x08 holds command pointer bits 63:32 and offset 0x0C holds bits 31:0. Both read back and drive `cmd_ptr`.
- R5: The selects sit at 0x10 (interrupt), 0x14 (branch) and 0x18 (wait). Each keeps its mask in written bits 23:16 and its value in bits 7:0, and reads back with every other bit zero.
- R6: Each condition output is high, in the same cycle, exactly when its select mask is nonzero and (mask AND status[7:0]) equals its value. The three conditions are independent of one another.
- R7: While `dev_stb` is high, each 1 in `dev_bits` sets the matching status bit 7:0 at the next edge. A control write whose mask covers the same bit in the same cycle wins.
- R8: A pulse on `done_stb` latches status[15:0] (the value before that edge's update) into `wb_xfer_status` and latches `done_resid` into `wb_resid`. Both hold until the next pulse.
- R9: Status reads at offset 0x04 as a 32-bit word with bits 31:16 zero, since no mask bit reaches them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| dev_stb | input | 1 | Device status set strobe |
| dev_bits | input | 8 | Device status bits to set |
| done_stb | input | 1 | Descriptor completion strobe |
| done_resid | input | 16 | Residual byte count at completion |
| cmd_ptr | output | 64 | Command pointer |
| cond_irq | output | 1 | Interrupt condition |
| cond_branch | output | 1 | Branch condition |
| cond_wait | output | 1 | Wait condition |
| wb_xfer_status | output | 16 | Latched status for writeback |
| wb_resid | output | 16 | Latched residual count for writeback |

## Verification
The hardest case to reach is a cycle where a masked control write and a device set strobe hit the same status bit together. The bench does not use its one-write task for this. It raises both inputs by hand in a single cycle, then reads status to confirm that the software value won on the covered bit while the hardware set still landed on an uncovered bit. The condition outputs are driven by walking status through values inside and outside each select's mask.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              dev_stb,
  input  logic [7:0]        dev_bits,
  input  logic              done_stb,
  input  logic [15:0]       done_resid,
  output logic [63:0]       cmd_ptr,
  output logic              cond_irq,
  output logic              cond_branch,
  output logic              cond_wait,
  output logic [15:0]       wb_xfer_status,
  output logic [15:0]       wb_resid
);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_PHI  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_PLO  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_SEL0 = ADDR_W'(8'h10);
  localparam int NSEL = 3;

  logic [15:0] st;
  logic [7:0]  smask [NSEL];
  logic [7:0]  sval  [NSEL];
  logic [NSEL-1:0] cond;

  wire        ctl_we = reg_wr && reg_addr == A_CTL;
  wire [15:0] m      = ctl_we ? reg_wdata[31:16] : 16'h0;
  wire [15:0] hw     = dev_stb ? {8'h0, dev_bits} : 16'h0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
      cmd_ptr <= '0;
      wb_xfer_status <= '0;
      wb_resid <= '0;
    end else begin
      st <= (reg_wdata[15:0] & m) | ((st | hw) & ~m);
      if (reg_wr && reg_addr == A_PHI) cmd_ptr[63:32] <= reg_wdata;
      if (reg_wr && reg_addr == A_PLO) cmd_ptr[31:0]  <= reg_wdata;
      if (done_stb) begin
        wb_xfer_status <= st;
        wb_resid <= done_resid;
      end
    end
  end

  for (genvar i = 0; i < NSEL; i++) begin : g_sel
    localparam logic [ADDR_W-1:0] A = A_SEL0 + ADDR_W'(4 * i);
    always_ff @(posedge clk) begin
      if (rst) begin
        smask[i] <= '0;
        sval[i]  <= '0;
      end else if (reg_wr && reg_addr == A) begin
        smask[i] <= reg_wdata[23:16];
        sval[i]  <= reg_wdata[7:0];
      end
    end
    assign cond[i] = (smask[i] != 8'h0) && ((smask[i] & st[7:0]) == sval[i]);
  end

  assign cond_irq    = cond[0];
  assign cond_branch = cond[1];
  assign cond_wait   = cond[2];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_STAT) reg_rdata = {16'h0, st};
    else if (reg_addr == A_PHI) reg_rdata = cmd_ptr[63:32];
    else if (reg_addr == A_PLO) reg_rdata = cmd_ptr[31:0];
    else
      for (int i = 0; i < NSEL; i++)
        if (reg_addr == A_SEL0 + ADDR_W'(4 * i))
          reg_rdata = {8'h0, smask[i], 8'h0, sval[i]};
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              dev_stb,
  input logic              done_stb,
  input logic [15:0]       done_resid,
  input logic [63:0]       cmd_ptr,
  input logic              cond_irq,
  input logic              cond_branch,
  input logic              cond_wait,
  input logic [15:0]       wb_resid,
  input logic [15:0]       st
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> !(cond_irq || cond_branch || cond_wait) && st == 16'h0);
  // R2
  unmasked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(8'h00) && !dev_stb) |=> ((st ^ $past(st)) & ~$past(reg_wdata[31:16])) == 16'h0);
  // R3
  stat_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(8'h04) && !dev_stb) |=> $stable(st));
  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && (reg_addr == ADDR_W'(8'h08) || reg_addr == ADDR_W'(8'h0C))) |=> $stable(cmd_ptr));
  // R8
  resid_latch_chk: assert property (@(posedge clk) disable iff (rst)
    done_stb |=> wb_resid == $past(done_resid));
  // R8
  resid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_stb |=> $stable(wb_resid));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .dev_stb(dev_stb), .done_stb(done_stb), .done_resid(done_resid), .cmd_ptr(cmd_ptr),
  .cond_irq(cond_irq), .cond_branch(cond_branch), .cond_wait(cond_wait),
  .wb_resid(wb_resid), .st(st)
);

// File: tb/sim_dma_chan_regs.sv
module sim_dma_chan_regs;
  logic clk = 0, rst = 1, reg_wr = 0, dev_stb = 0, done_stb = 0;
  logic [7:0] reg_addr = 0, dev_bits = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [15:0] done_resid = 0, wb_xfer_status, wb_resid;
  logic [63:0] cmd_ptr;
  logic cond_irq, cond_branch, cond_wait;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_chan_regs u0 (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h04, d); chk("R1 status", d, 0);
    chk("R1 conds", {cond_irq, cond_branch, cond_wait}, 0);
    chk("R1 ptr", cmd_ptr, 0);
  endtask

  task automatic t_masked;
    logic [31:0] d;
    wr(8'h00, 32'h00F0_FFFF); rd(8'h04, d); chk("R2 first", d, 32'h00F0);
    wr(8'h00, 32'h0F00_0A00); rd(8'h04, d); chk("R2 second", d, 32'h0AF0);
    wr(8'h00, 32'h00F0_0000); rd(8'h04, d); chk("R2 clear", d, 32'h0A00);
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h04, d); chk("R9 upper zero", d, 32'h0000_FFFF);
    wr(8'h00, 32'hFFFF_0A00);
  endtask

  task automatic t_ignored;
    logic [31:0] d;
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d); chk("R3 status write", d, 32'h0A00);
    rd(8'h00, d); chk("R3 ctl read", d, 0);
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, d); chk("R3 unmapped read", d, 0);
    rd(8'h04, d); chk("R3 unmapped write", d, 32'h0A00);
    chk("R3 unmapped ptr", cmd_ptr, 0);
  endtask

  task automatic t_ptr;
    logic [31:0] d;
    wr(8'h08, 32'hDEAD_BEEF); wr(8'h0C, 32'h1234_5678);
    chk("R4 port", cmd_ptr, 64'hDEAD_BEEF_1234_5678);
    rd(8'h08, d); chk("R4 hi", d, 32'hDEAD_BEEF);
    rd(8'h0C, d); chk("R4 lo", d, 32'h1234_5678);
  endtask

  task automatic t_sel;
    logic [31:0] d;
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d); chk("R5 layout", d, 32'h00FF_00FF);
    wr(8'h10, 32'h0003_0001); wr(8'h14, 32'h0080_0080); wr(8'h18, 32'h0080_0000);
    rd(8'h14, d); chk("R5 branch read", d, 32'h0080_0080);
    wr(8'h00, 32'h00FF_0000);
    chk("R6 none", {cond_irq, cond_branch, cond_wait}, 3'b001);
    wr(8'h00, 32'h0011_0011);
    chk("R6 irq match", {cond_irq, cond_branch, cond_wait}, 3'b101);
    wr(8'h00, 32'h0082_0082);
    chk("R6 mismatch", {cond_irq, cond_branch, cond_wait}, 3'b010);
  endtask

  task automatic t_dev;
    logic [31:0] d;
    wr(8'h00, 32'h00FF_0000);
    @(negedge clk); dev_stb = 1; dev_bits = 8'h44;
    @(negedge clk); dev_stb = 0;
    rd(8'h04, d); chk("R7 set", d, 32'h0A44);
    @(negedge clk); dev_stb = 1; dev_bits = 8'h0C; reg_wr = 1; reg_addr = 8'h00; reg_wdata = 32'h0004_0000;
    @(negedge clk); dev_stb = 0; reg_wr = 0;
    rd(8'h04, d); chk("R7 sw wins", d, 32'h0A48);
  endtask

  task automatic t_wb;
    @(negedge clk); done_stb = 1; done_resid = 16'h0123;
    @(negedge clk); done_stb = 0; done_resid = 16'h9999;
    chk("R8 status", wb_xfer_status, 16'h0A48);
    chk("R8 resid", wb_resid, 16'h0123);
    wr(8'h00, 32'hFFFF_0000);
    chk("R8 hold", {wb_xfer_status, wb_resid}, {16'h0A48, 16'h0123});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset(); t_masked(); t_ignored(); t_ptr(); t_sel(); t_dev(); t_wb();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule